// File: doc/BRIEF.md
# Dual-Copy Register File with Basic-Block Checkpointing

This block holds the architectural integer registers in two full physical copies. A one-bit mapping per register selects the copy that holds its newest value. A per-register dirty bit records whether the running basic block has already written that register. On the first write to a register inside a block, the data goes to the copy that does not hold the live value, and the mapping bit flips. The value the register had at the start of the block therefore stays intact in the other copy. Later writes to the same register in the same block overwrite the copy the mapping already selects. Restoring the machine to the start of the block is then only a restore of the mapping bits. No register data is copied.

A small ring of mapping snapshots has one entry for each basic block in flight plus one. The pipeline strobes `blk_end` when a block closes. The current mapping, including any write in that cycle, is pushed as the checkpoint for the block that follows, and the dirty mask clears. `blk_commit` retires the oldest snapshot once a younger one exists. `rollback` reloads the mapping from the newest snapshot, which is the start of the running block, and clears the dirty mask. `stall` tells the front end that every snapshot slot is taken, so a further block end cannot be recorded.

The write port is valid/ready. A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only in a cycle where `rollback` is high. The producer must hold its write across such a cycle and present it again. Read ports are plain combinational lookups. The control strobes are single-cycle pulses with no handshake.

Top module: `rfck_dual_rf`

## Requirements
- R1: After reset every register reads 0, every mapping bit selects copy 0, one snapshot is held and `stall` is low.
- R2: A read port returns the data of the most recent accepted write to the addressed register that has not been undone by a rollback.
- R3: When an accepted write in the same cycle targets the address on a read port, that port returns the write data.
- R4: The first accepted write to a register after reset, after an accepted block end or after a rollback flips that register's mapping bit. A following rollback makes the register read its value from before that write.
- R5: Further accepted writes to an already dirty register leave its mapping bit unchanged. A rollback returns the value from the start of the block, not any intermediate value.
- R6: An accepted block end clears the dirty mask and records a snapshot that includes any write accepted in the same cycle. Values written before it survive a later rollback.
- R7: `stall` is high exactly when the number of held snapshots equals MAX_BLOCKS+1. A block end is accepted only when `stall` is low and `rollback` is low.
- R8: A block end strobed while `stall` is high records nothing and leaves the dirty mask as it was. A later rollback therefore still returns to the previous snapshot.
- R9: `blk_commit` frees the oldest snapshot when more than one is held and is ignored when only one is held. A commit in the same cycle as a block end leaves the count unchanged.
- R10: In a cycle with `rollback` high, `wr_ready` is low and both a write and a block end offered in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_addr | input | $clog2(NUM_REGS) | Register to write |
| wr_data | input | DATA_W | Write data |
| rd_addr0 | input | $clog2(NUM_REGS) | Read port 0 address |
| rd_data0 | output | DATA_W | Read port 0 data |
| rd_addr1 | input | $clog2(NUM_REGS) | Read port 1 address |
| rd_data1 | output | DATA_W | Read port 1 data |
| blk_end | input | 1 | Current basic block closes |
| blk_commit | input | 1 | Oldest in-flight block retires |
| rollback | input | 1 | Return to the start of the running block |
| stall | output | 1 | All snapshot slots in use |

## Verification
The bench builds the block with 16 registers of 32 bits and MAX_BLOCKS set to 2, so the ring has three slots. Two block ends fill it. This brings the full ring, an ignored block end and commits back down to a single slot within a few cycles of any point in a random run. Random strobes mix rollbacks with repeated writes to the same few registers. This exercises first and later writes in a block, forwarding on both read ports, and write/rollback collisions against a value-level model that knows nothing of copies or mapping bits.

// File: rtl/rfck_pkg.sv
package rfck_pkg;
  // Action applied to the per-register mapping/dirty state in a cycle.
  typedef enum logic [1:0] {
    MAP_HOLD    = 2'd0,
    MAP_CLOSE   = 2'd1,
    MAP_RESTORE = 2'd2
  } map_op_e;
endpackage

// File: rtl/rfck_bank.sv
module rfck_bank #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic                wsel,
  input  logic [AW-1:0]       waddr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_REGS-1:0] map,
  input  logic [AW-1:0]       raddr0,
  input  logic [AW-1:0]       raddr1,
  output logic [DATA_W-1:0]   rdata0,
  output logic [DATA_W-1:0]   rdata1
);
  logic [DATA_W-1:0] rd0_c [2];
  logic [DATA_W-1:0] rd1_c [2];

  for (genvar c = 0; c < 2; c++) begin : g_copy
    logic [DATA_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
      end else if (we && (wsel == 1'(c))) begin
        mem[waddr] <= wdata;
      end
    end

    assign rd0_c[c] = mem[raddr0];
    assign rd1_c[c] = mem[raddr1];
  end

  assign rdata0 = rd0_c[map[raddr0]];
  assign rdata1 = rd1_c[map[raddr1]];
endmodule

// File: rtl/rfck_map.sv
module rfck_map
  import rfck_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_fire,
  input  logic [AW-1:0]       wr_addr,
  input  map_op_e             op,
  input  logic [NUM_REGS-1:0] restore_map,
  output logic [NUM_REGS-1:0] cur_map,
  output logic [NUM_REGS-1:0] dirty_mask,
  output logic [NUM_REGS-1:0] next_map,
  output logic                wr_sel
);
  logic [NUM_REGS-1:0] wr_onehot;
  logic                first_wr;

  always_comb begin
    wr_onehot          = '0;
    wr_onehot[wr_addr] = wr_fire;
  end

  assign first_wr = wr_fire && !dirty_mask[wr_addr];
  assign wr_sel   = first_wr ? ~cur_map[wr_addr] : cur_map[wr_addr];
  assign next_map = first_wr ? (cur_map ^ wr_onehot) : cur_map;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_map    <= '0;
      dirty_mask <= '0;
    end else begin
      case (op)
        MAP_RESTORE: begin
          cur_map    <= restore_map;
          dirty_mask <= '0;
        end
        MAP_CLOSE: begin
          cur_map    <= next_map;
          dirty_mask <= '0;
        end
        default: begin
          cur_map    <= next_map;
          dirty_mask <= dirty_mask | wr_onehot;
        end
      endcase
    end
  end
endmodule

// File: rtl/rfck_ring.sv
module rfck_ring #(
  parameter int NUM_REGS = 16,
  parameter int DEPTH    = 4,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int SUM_W   = $clog2(2 * DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic                commit,
  input  logic [NUM_REGS-1:0] push_map,
  output logic [NUM_REGS-1:0] newest_map,
  output logic                full
);
  localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);

  logic [NUM_REGS-1:0] slot [DEPTH];
  logic [PTR_W-1:0]    head;
  logic [CNT_W-1:0]    count;
  logic                pop;
  logic [PTR_W-1:0]    tail_idx;
  logic [PTR_W-1:0]    newest_idx;
  logic [PTR_W-1:0]    head_nxt;

  function automatic logic [PTR_W-1:0] wrap(input logic [SUM_W-1:0] v);
    return (v >= DEPTH_S) ? PTR_W'(v - DEPTH_S) : PTR_W'(v);
  endfunction

  assign full       = (count == CNT_W'(DEPTH));
  assign pop        = commit && (count > CNT_W'(1));
  assign tail_idx   = wrap(SUM_W'(head) + SUM_W'(count));
  assign newest_idx = wrap(SUM_W'(head) + SUM_W'(count) - SUM_W'(1));
  assign head_nxt   = wrap(SUM_W'(head) + SUM_W'(1));
  assign newest_map = slot[newest_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      head  <= '0;
      count <= CNT_W'(1);
    end else begin
      if (push) slot[tail_idx] <= push_map;
      if (pop)  head <= head_nxt;
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rfck_dual_rf.sv
module rfck_dual_rf
  import rfck_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int DATA_W     = 32,
  parameter int MAX_BLOCKS = 3,
  localparam int AW        = $clog2(NUM_REGS),
  localparam int DEPTH     = MAX_BLOCKS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr0,
  output logic [DATA_W-1:0] rd_data0,
  input  logic [AW-1:0]     rd_addr1,
  output logic [DATA_W-1:0] rd_data1,
  input  logic              blk_end,
  input  logic              blk_commit,
  input  logic              rollback,
  output logic              stall
);
  logic                wr_fire;
  logic                close_ok;
  logic                wr_sel;
  map_op_e             map_op;
  logic [NUM_REGS-1:0] cur_map;
  logic [NUM_REGS-1:0] dirty_mask;
  logic [NUM_REGS-1:0] next_map;
  logic [NUM_REGS-1:0] newest_map;
  logic [DATA_W-1:0]   bank_rd0;
  logic [DATA_W-1:0]   bank_rd1;

  assign wr_ready = !rollback;
  assign wr_fire  = wr_valid && wr_ready;
  assign close_ok = blk_end && !rollback && !stall;

  always_comb begin
    if (rollback)      map_op = MAP_RESTORE;
    else if (close_ok) map_op = MAP_CLOSE;
    else               map_op = MAP_HOLD;
  end

  rfck_map #(.NUM_REGS(NUM_REGS)) i_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_addr    (wr_addr),
    .op         (map_op),
    .restore_map(newest_map),
    .cur_map    (cur_map),
    .dirty_mask (dirty_mask),
    .next_map   (next_map),
    .wr_sel     (wr_sel)
  );

  rfck_ring #(.NUM_REGS(NUM_REGS), .DEPTH(DEPTH)) i_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (close_ok),
    .commit    (blk_commit),
    .push_map  (next_map),
    .newest_map(newest_map),
    .full      (stall)
  );

  rfck_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_fire),
    .wsel   (wr_sel),
    .waddr  (wr_addr),
    .wdata  (wr_data),
    .map    (cur_map),
    .raddr0 (rd_addr0),
    .raddr1 (rd_addr1),
    .rdata0 (bank_rd0),
    .rdata1 (bank_rd1)
  );

  assign rd_data0 = (wr_fire && (wr_addr == rd_addr0)) ? wr_data : bank_rd0;
  assign rd_data1 = (wr_fire && (wr_addr == rd_addr1)) ? wr_data : bank_rd1;
endmodule

// File: rtl/rfck_checker.sv
module rfck_checker #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_valid,
  input logic                wr_ready,
  input logic [AW-1:0]       wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic [AW-1:0]       rd_addr0,
  input logic [DATA_W-1:0]   rd_data0,
  input logic                blk_end,
  input logic                blk_commit,
  input logic                rollback,
  input logic                stall,
  input logic [NUM_REGS-1:0] cur_map,
  input logic [NUM_REGS-1:0] dirty_mask
);
  assert_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && (wr_addr == rd_addr0)) |-> (rd_data0 == wr_data));

  assert_first_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !dirty_mask[wr_addr])
      |=> (cur_map[$past(wr_addr)] != $past(cur_map[wr_addr])));

  assert_later_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && dirty_mask[wr_addr])
      |=> (cur_map[$past(wr_addr)] == $past(cur_map[wr_addr])));

  assert_dirty_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rollback || (blk_end && !stall)) |=> (dirty_mask == '0));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !blk_commit) |=> stall);

  assert_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |-> !wr_ready);
endmodule

bind rfck_dual_rf rfck_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_addr0  (rd_addr0),
  .rd_data0  (rd_data0),
  .blk_end   (blk_end),
  .blk_commit(blk_commit),
  .rollback  (rollback),
  .stall     (stall),
  .cur_map   (cur_map),
  .dirty_mask(dirty_mask)
);

// File: tb/test_rfck_dual_rf.sv
module test_rfck_dual_rf;
  localparam int NR    = 16;
  localparam int DW    = 32;
  localparam int MB    = 2;
  localparam int DEPTH = MB + 1;
  localparam int AW    = $clog2(NR);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr0 = '0;
  logic [DW-1:0] rd_data0;
  logic [AW-1:0] rd_addr1 = '0;
  logic [DW-1:0] rd_data1;
  logic          blk_end = 1'b0;
  logic          blk_commit = 1'b0;
  logic          rollback = 1'b0;
  logic          stall;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_cur   [NR];
  logic [DW-1:0] m_start [NR];
  int            m_cnt;

  always #4 clk = ~clk;

  rfck_dual_rf #(.NUM_REGS(NR), .DATA_W(DW), .MAX_BLOCKS(MB)) i_rfck_dual_rf (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr0(rd_addr0), .rd_data0(rd_data0),
    .rd_addr1(rd_addr1), .rd_data1(rd_data1), .blk_end(blk_end),
    .blk_commit(blk_commit), .rollback(rollback), .stall(stall)
  );

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] ra, input bit wv,
      input logic [AW-1:0] wa, input logic [DW-1:0] wd, input bit rb);
    return (wv && !rb && wa == ra) ? wd : m_cur[ra];
  endfunction

  // One cycle: drive, check outputs, then advance the model.
  task automatic cyc(input bit wv, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
      input bit be, input bit bc, input bit rb,
      input logic [AW-1:0] ra0, input logic [AW-1:0] ra1, input string tag);
    bit fwd0, fwd1, full;
    @(negedge clk);
    wr_valid = wv; wr_addr = wa; wr_data = wd;
    blk_end = be; blk_commit = bc; rollback = rb;
    rd_addr0 = ra0; rd_addr1 = ra1;
    #1;
    fwd0 = wv && !rb && wa == ra0;
    fwd1 = wv && !rb && wa == ra1;
    check(rd_data0, expect_rd(ra0, wv, wa, wd, rb), fwd0 ? "R3 port0" : tag);
    check(rd_data1, expect_rd(ra1, wv, wa, wd, rb), fwd1 ? "R3 port1" : tag);
    full = (m_cnt == DEPTH);
    check({31'd0, stall}, {31'd0, full}, "R7 stall");
    check({31'd0, wr_ready}, {31'd0, !rb}, "R10 wr_ready");
    if (rb) begin
      for (int i = 0; i < NR; i++) m_cur[i] = m_start[i];
      if (bc && m_cnt > 1) m_cnt--;
    end else begin
      if (wv) m_cur[wa] = wd;
      if (be && !full) begin
        for (int i = 0; i < NR; i++) m_start[i] = m_cur[i];
        if (!(bc && m_cnt > 1)) m_cnt++;
      end else if (bc && m_cnt > 1) begin
        m_cnt--;
      end
    end
  endtask

  task automatic idle_rd(input logic [AW-1:0] ra, input string tag);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, ra, ra, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NR; i++) begin m_cur[i] = '0; m_start[i] = '0; end
    m_cnt = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents and stall
    for (int r = 0; r < NR; r += 2) idle_rd(AW'(r), "R1 reset");

    // R4/R5/R6: snapshot with write, then overwrite twice, roll back
    cyc(1'b1, 4'd3, 32'hA1A1_0003, 1'b1, 1'b0, 1'b0, 4'd3, 4'd4, "R6 close");
    idle_rd(4'd3, "R2 after close");
    cyc(1'b1, 4'd3, 32'hB2B2_0003, 1'b0, 1'b0, 1'b0, 4'd3, 4'd3, "R4 first");
    cyc(1'b1, 4'd3, 32'hC3C3_0003, 1'b0, 1'b0, 1'b0, 4'd1, 4'd3, "R5 later");
    idle_rd(4'd3, "R5 latest");
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 4'd3, 4'd3, "R5 rollback");
    idle_rd(4'd3, "R4 restored");
    cyc(1'b1, 4'd3, 32'hD4D4_0003, 1'b0, 1'b0, 1'b0, 4'd2, 4'd2, "R4 rewrite");
    idle_rd(4'd3, "R4 rewrite read");

    // R7/R8: fill ring, block end while full ignored
    cyc(1'b0, '0, '0, 1'b1, 1'b0, 1'b0, 4'd3, 4'd5, "R7 fill");
    idle_rd(4'd5, "R7 full");
    cyc(1'b1, 4'd5, 32'h5555_AAAA, 1'b0, 1'b0, 1'b0, 4'd0, 4'd1, "R8 write");
    cyc(1'b0, '0, '0, 1'b1, 1'b0, 1'b0, 4'd5, 4'd5, "R8 ignored end");
    cyc(1'b1, 4'd5, 32'h6666_0000, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0, "R8 write2");
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 4'd5, 4'd5, "R8 rollback");
    idle_rd(4'd5, "R8 restored");

    // R9: commits free slots; extra commit ignored
    cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, 4'd3, 4'd5, "R9 commit");
    cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, 4'd3, 4'd5, "R9 commit");
    cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, 4'd3, 4'd5, "R9 extra");
    cyc(1'b0, '0, '0, 1'b1, 1'b1, 1'b0, 4'd3, 4'd5, "R9 end+commit");
    idle_rd(4'd3, "R9 count");

    // R10: write and block end offered during rollback are dropped
    cyc(1'b1, 4'd7, 32'h7777_7777, 1'b1, 1'b0, 1'b1, 4'd7, 4'd7, "R10 collide");
    idle_rd(4'd7, "R10 dropped");
    idle_rd(4'd3, "R10 state");

    // Random mix, few registers to force repeats
    for (int n = 0; n < 4000; n++) begin
      bit wv, be, bc, rb;
      logic [AW-1:0] wa, a0, a1;
      wv = ($urandom % 2) == 0;
      be = ($urandom % 8) == 0;
      bc = ($urandom % 8) == 0;
      rb = ($urandom % 20) == 0;
      wa = AW'($urandom % 6);
      a0 = AW'($urandom % 6);
      a1 = AW'($urandom % NR);
      cyc(wv, wa, $urandom, be, bc, rb, a0, a1, "R2 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule